// File: doc/BRIEF.md
# Two-Bank Mixed-Trigger Interrupt Controller

This block gathers 64 interrupt sources into one interrupt line for a single CPU. The sources are held in two 32-bit banks. Each bank keeps a register of latched events, an enable mask, a copy of the current input levels, and a fixed per-bit map that marks each source as edge-latched or level-sensitive. Every clock the block samples each source and copies it into its level bit. An edge-latched source that is seen high also sets its event bit, and that bit stays set until software clears it. A level-sensitive source sets no event bit. Its level bit drives the request directly for as long as the input stays high.

Software reaches the block through a simple synchronous register bus. The bus has separate read and write strobes, a 12-bit address inside a 4 KB window, and 32-bit data. Software sets the enable masks, reads the event and level registers, and clears events by writing ones. Clear writes have no effect on bits that are marked level-sensitive. The CPU interrupt output is a registered OR of the two bank requests.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, every event, mask and level register in both banks reads 0 and `irq_o` is low. The level-sensitive map is fixed at reset: bank 0 is 0x00000000 and bank 1 is 0x1FF00000, so sources 20 to 28 are level-sensitive.
- R2: An edge-latched source that is sampled high sets its level bit and its event bit. Once the source is sampled low, its level bit is 0 and its event bit stays 1.
- R3: A level-sensitive source never sets its event bit. If it is enabled, it requests an interrupt while it is sampled high, and `irq_o` falls on the clock edge after it is sampled low.
- R4: A bank requests service when `(events | (levels & level_map)) & mask` is nonzero. `irq_o` is the OR of the two bank requests. It takes the new value at the same clock edge that registers a mask write, a clear write or a sampled input change.
- R5: A write to the clear offset (0x8) clears each event bit that is 1 in the write data, but only on edge-latched bits. Level-sensitive bits in the write data are ignored. An edge source that is still sampled high in the clear cycle keeps its event set.
- R6: Bank 0 is at 0x10 to 0x1F and bank 1 is at 0x20 to 0x2F. Within a bank, offset 0x0 reads the events, 0x4 reads and writes the mask, 0x8 is the write-only clear port and reads 0, and 0xC reads the levels. Read data appears on `rdata_o` one clock after `rd_en` and is held until the next read.
- R7: Reads return 0 and writes are ignored when the bank index `(addr - 0x10) >> 4` is not 0 or 1, or when the offset within the bank is not 0x0, 0x4, 0x8 or 0xC.
- R8: Source n is held in bank `1 - (n >> 5)` at bit `n & 31`. Sources 0 to 31 therefore appear in bank 1 (0x20) and sources 32 to 63 appear in bank 0 (0x10).
- R9: Under any mix of source changes, mask writes, clear writes and reads, `irq_o` and the read data follow R2 to R8 on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 64 | Interrupt source inputs, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte address inside the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
The first pattern is an edge source raised, held and dropped. It separates the latched event bit from the level bit, and it shows that bank selection runs in reverse to source numbering. The second pattern is a level-sensitive source in the 20 to 28 range driven under a mask while clears are aimed at it. It separates pass-through from latching and shows that the clear is blocked on such bits. The third pattern is a clear issued while an edge source is still held high, which tells set-wins ordering apart from clear-wins ordering. A long random mix of source flips, mask and clear writes, and reads to valid and invalid addresses is then compared against a behavioural model on every clock, which exposes any decode hole or any cycle the output is late.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned INTC_BANK_W = 32;
  localparam int unsigned INTC_ADDR_W = 12;
  localparam logic [INTC_ADDR_W-1:0] INTC_BASE = 12'h010;

  typedef enum logic [3:0] {
    OFF_EVT  = 4'h0,
    OFF_MASK = 4'h4,
    OFF_CLR  = 4'h8,
    OFF_LVL  = 4'hC
  } intc_off_e;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int unsigned NB = 2,
  parameter int unsigned AW = INTC_ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  output logic [NB-1:0] bank_hit_o,
  output logic [3:0]    off_o
);
  localparam int unsigned IW = AW - 4;

  logic [AW-1:0] rel;
  logic [IW-1:0] idx;

  always_comb begin
    rel = addr_i - AW'(INTC_BASE);
    idx = rel[AW-1:4];
    off_o = addr_i[3:0];
  end

  for (genvar b = 0; b < NB; b++) begin : g_hit
    assign bank_hit_o[b] = (idx == IW'(b));
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int unsigned BW = 32,
  parameter logic [BW-1:0] LT_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] src_i,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] ev_o,
  output logic [BW-1:0] mask_o,
  output logic [BW-1:0] lvl_o,
  output logic          req_next_o
);
  logic [BW-1:0] ev_q, ev_d;
  logic [BW-1:0] mask_q, mask_d;
  logic [BW-1:0] lvl_q, lvl_d;
  logic [BW-1:0] lt_q;
  logic [BW-1:0] clr_bits;

  always_comb begin
    clr_bits   = clr_we ? (wdata_i & ~lt_q) : '0;
    ev_d       = (ev_q & ~clr_bits) | (src_i & ~lt_q);
    mask_d     = mask_we ? wdata_i : mask_q;
    lvl_d      = src_i;
    req_next_o = |((ev_d | (lvl_d & lt_q)) & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
      lt_q   <= LT_INIT;
    end else begin
      ev_q  <= ev_d;
      lvl_q <= lvl_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign ev_o   = ev_q;
  assign mask_o = mask_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned NB = 2,
  parameter int unsigned BW = INTC_BANK_W,
  parameter int unsigned AW = INTC_ADDR_W,
  parameter logic [NB*BW-1:0] LT_INIT = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   src_i,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [11:0]   addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o
);
  localparam int unsigned NSRC = NB * BW;

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic [NB-1:0] bank_hit;
  logic [3:0]    off;
  logic [NB-1:0] req_next;
  logic [BW-1:0] ev_w   [NB];
  logic [BW-1:0] mask_w [NB];
  logic [BW-1:0] lvl_w  [NB];
  logic [NSRC-1:0] ev_flat;
  logic [NSRC-1:0] mask_flat;
  logic [BW-1:0] rd_val;
  logic [BW-1:0] rdata_q;
  logic          irq_q, irq_d;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  intc_decode #(.NB(NB), .AW(AW)) u_dec (
    .addr_i     (addr_i),
    .bank_hit_o (bank_hit),
    .off_o      (off)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    // lower-numbered sources sit in the higher bank
    intc_bank #(.BW(BW), .LT_INIT(LT_INIT[b*BW +: BW])) u_bank (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .src_i      (src_i[(NB-1-b)*BW +: BW]),
      .mask_we    (wr_en && bank_hit[b] && (off == OFF_MASK)),
      .clr_we     (wr_en && bank_hit[b] && (off == OFF_CLR)),
      .wdata_i    (wdata_i),
      .ev_o       (ev_w[b]),
      .mask_o     (mask_w[b]),
      .lvl_o      (lvl_w[b]),
      .req_next_o (req_next[b])
    );
    assign ev_flat[b*BW +: BW]   = ev_w[b];
    assign mask_flat[b*BW +: BW] = mask_w[b];
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_hit[b]) begin
        case (off)
          OFF_EVT:  rd_val = ev_w[b];
          OFF_MASK: rd_val = mask_w[b];
          OFF_LVL:  rd_val = lvl_w[b];
          default:  rd_val = '0;
        endcase
      end
    end
    irq_d = |req_next;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (rd_en) rdata_q <= rd_val;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dual_bank_intc_checker.sv
module dual_bank_intc_checker #(
  parameter int unsigned NB = 2,
  parameter int unsigned BW = 32,
  parameter logic [NB*BW-1:0] LT_INIT = {32'h1FF0_0000, 32'h0000_0000}
) (
  input logic             clk,
  input logic             rst_n,
  input logic [63:0]      src_i,
  input logic             wr_en,
  input logic             rd_en,
  input logic [11:0]      addr_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             irq_o,
  input logic [NB*BW-1:0] ev_flat,
  input logic [NB*BW-1:0] mask_flat
);
  logic [NB*BW-1:0] src_by_bank;
  logic             addr_ok;

  always_comb begin
    for (int b = 0; b < NB; b++)
      src_by_bank[b*BW +: BW] = src_i[(NB-1-b)*BW +: BW];
    addr_ok = (addr_i >= 12'h010) && (int'(addr_i) < 16 + 16 * int'(NB)) &&
              ((addr_i[3:0] == 4'h0) || (addr_i[3:0] == 4'h4) ||
               (addr_i[3:0] == 4'hC) || (addr_i[3:0] == 4'h8));
  end

  // R2: an enabled edge source seen high raises the output next clock
  p_edge_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_by_bank & ~LT_INIT & mask_flat)) && !wr_en |=> irq_o);

  // R3: level-sensitive bits never hold a latched event
  p_lvl_no_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flat & LT_INIT) == '0);

  // R4: nothing enabled means no request
  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flat == '0) |-> !irq_o);

  // R5: clear on bank 0 removes written bits whose source was low
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr_i == 12'h018) |=>
      (ev_flat[BW-1:0] & $past(wdata_i & ~src_by_bank[BW-1:0])) == '0);

  // R7: a read outside the map returns zero
  p_hole_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !addr_ok |=> rdata_o == '0);
endmodule

bind dual_bank_intc dual_bank_intc_checker #(.NB(NB), .BW(BW), .LT_INIT(LT_INIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .ev_flat   (ev_flat),
  .mask_flat (mask_flat)
);

// File: tb/dual_bank_intc_bench.sv
`timescale 1ns/1ps
module dual_bank_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_ev [2];
  logic [31:0] m_mk [2];
  logic [31:0] m_lv [2];
  logic [31:0] m_lt [2];
  logic        m_irq;
  logic [31:0] m_rd;
  bit          m_rd_chk;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int ai = int'(a);
    int b;
    if (ai < 16 || ai >= 48) return 32'h0;
    b = (ai - 16) / 16;
    case (ai % 16)
      0:  return m_ev[b];
      4:  return m_mk[b];
      12: return m_lv[b];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        m_ev[b] = 0; m_mk[b] = 0; m_lv[b] = 0;
      end
      m_lt[0] = 32'h0; m_lt[1] = 32'h1FF0_0000;
      m_irq = 0; m_rd_chk = 0; m_rd = 0;
    end else begin
      logic [31:0] sb;
      int ai;
      int wb;
      m_rd_chk = rd_en;
      if (rd_en) m_rd = m_read(addr);
      ai = int'(addr);
      wb = (ai >= 16 && ai < 48) ? (ai - 16) / 16 : -1;
      if (wr_en && wb >= 0 && ai % 16 == 8) m_ev[wb] = m_ev[wb] & ~(wdata & ~m_lt[wb]);
      if (wr_en && wb >= 0 && ai % 16 == 4) m_mk[wb] = wdata;
      m_irq = 0;
      for (int b = 0; b < 2; b++) begin
        sb = src[(1-b)*32 +: 32];
        m_ev[b] = m_ev[b] | (sb & ~m_lt[b]);
        m_lv[b] = sb;
        if (((m_ev[b] | (m_lv[b] & m_lt[b])) & m_mk[b]) != 0) m_irq = 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " irq R4"}, {31'h0, irq}, {31'h0, m_irq});
      if (m_rd_chk) check({cur_req, " rdata R6"}, rdata, m_rd);
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic set_src(input int n, input logic v);
    @(negedge clk);
    src[n] = v;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] alist [10];
    alist = '{12'h010, 12'h014, 12'h018, 12'h01C, 12'h020,
              12'h024, 12'h028, 12'h02C, 12'h034, 12'h012};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur_req = "R1";
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    rd_chk("R1 bank0 events", 12'h010, 0);
    rd_chk("R1 bank0 mask",   12'h014, 0);
    rd_chk("R1 bank0 levels", 12'h01C, 0);
    rd_chk("R1 bank1 events", 12'h020, 0);
    rd_chk("R1 bank1 mask",   12'h024, 0);
    rd_chk("R1 bank1 levels", 12'h02C, 0);

    cur_req = "R2";
    set_src(5, 1);
    rd_chk("R2 R8 src5 event in bank1", 12'h020, 32'h20);
    rd_chk("R2 src5 level",             12'h02C, 32'h20);
    rd_chk("R8 bank0 untouched",        12'h010, 0);
    set_src(40, 1);
    rd_chk("R8 src40 in bank0 bit8",    12'h010, 32'h100);
    set_src(5, 0);
    rd_chk("R2 level dropped",          12'h02C, 0);
    rd_chk("R2 event kept",             12'h020, 32'h20);

    cur_req = "R4";
    check("R4 no irq while masked off", {31'h0, irq}, 0);
    bus_wr(12'h024, 32'h20);
    check("R4 irq one clock after mask", {31'h0, irq}, 1);
    bus_wr(12'h024, 32'h0);
    check("R4 irq drops on unmask", {31'h0, irq}, 0);

    cur_req = "R5";
    bus_wr(12'h024, 32'h20);
    bus_wr(12'h028, 32'h20);
    check("R5 irq off after clear", {31'h0, irq}, 0);
    rd_chk("R5 event cleared", 12'h020, 0);
    set_src(5, 1);
    bus_wr(12'h028, 32'h20);
    rd_chk("R5 held source relatches", 12'h020, 32'h20);
    set_src(5, 0);
    bus_wr(12'h028, 32'h20);

    cur_req = "R3";
    set_src(24, 1);
    rd_chk("R3 no event for level source", 12'h020, 0);
    rd_chk("R3 level visible", 12'h02C, 32'h0100_0000);
    bus_wr(12'h024, 32'h0100_0000);
    check("R3 level source requests", {31'h0, irq}, 1);
    bus_wr(12'h028, 32'h0100_0000);
    check("R5 clear ignores level bit", {31'h0, irq}, 1);
    @(negedge clk); src[24] = 0;
    @(negedge clk);
    check("R3 irq falls after level drop", {31'h0, irq}, 0);

    cur_req = "R4";
    bus_wr(12'h014, 32'h100);
    check("R4 bank0 alone raises irq", {31'h0, irq}, 1);
    bus_wr(12'h014, 32'h0);

    cur_req = "R7";
    bus_wr(12'h034, 32'hFFFF_FFFF);
    bus_wr(12'h004, 32'hFFFF_FFFF);
    bus_wr(12'h015, 32'hFFFF_FFFF);
    bus_wr(12'h110, 32'hFFFF_FFFF);
    rd_chk("R7 bank0 mask unchanged", 12'h014, 0);
    rd_chk("R7 bank1 mask unchanged", 12'h024, 32'h0100_0000);
    rd_chk("R6 clear port reads zero", 12'h028, 0);
    rd_chk("R7 invalid bank reads zero", 12'h034, 0);
    rd_chk("R7 odd offset reads zero", 12'h011, 0);
    rd_chk("R7 far index reads zero", 12'h110, 0);
    rd_chk("R7 below window reads zero", 12'h000, 0);

    cur_req = "R9";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      if ($urandom_range(3) == 0) src[$urandom_range(63)] ^= 1'b1;
      case ($urandom_range(2))
        0: begin wr_en = 1; addr = alist[$urandom_range(9)]; wdata = $urandom; end
        1: begin rd_en = 1; addr = alist[$urandom_range(9)]; end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule